// File: doc/BRIEF.md
# Sticky Prioritised Error Code Reporter

This block watches a set of single-cycle error strobes from a serial audio receiver. It keeps the most severe error it has seen since the last clear, as a small numeric code. The code comes out on three pins, which the chip shares with its channel-status outputs. The code drives those pins only while the select input is low. While select is high, the block drives zeros and leaves the pins to the other function.

The block has no reset pin. A clear comes from the select input alone. Select must be sampled high on more than `CLR_LEN` (default 8) consecutive master-clock edges, so the clear takes effect on the ninth edge. Shorter select-high pulses switch the pins over to the other function and do not disturb the held code. A small state machine times the select input:

- **ST_WATCH**: select is low. Errors are gathered.
- **ST_COUNT**: select is high, `CLR_LEN` samples or fewer so far. Errors are still gathered.
- **ST_CLEAR**: the long pulse has been seen. The code is held at zero.

Transitions:

- **go_count**: WATCH to COUNT, on a high sample.
- **stay_count**: COUNT to COUNT, while the counter is below the limit.
- **go_clear**: COUNT to CLEAR, on the high sample that reaches the limit.
- **hold_clear**: CLEAR to CLEAR, while select stays high.
- **go_watch**: any state to WATCH, on a low sample. This also zeroes the counter.

Top module: `sticky_err_reporter`

## Requirements
- R1: Error strobe bit i (0..6) has code i+1. Bit 0 is validity (1), bit 1 confidence (2), bit 2 slew (3), bit 3 CRC (4), bit 4 parity (5), bit 5 biphase (6) and bit 6 loss of lock (7). Code 0 means no error. A strobe sampled at a clock edge appears on `err_code` after that edge.
- R2: When several strobes are sampled together, the code taken is the one of the highest set bit.
- R3: A held code stays on `err_code` after the strobe that set it has gone away.
- R4: A new error replaces the held code only if its code is strictly greater. A lower or equal error leaves the code unchanged.
- R5: While `sel_in` is high, `err_code` reads 0. When `sel_in` is low, it shows the held code.
- R6: A select-high run of 1 to 8 consecutive sampled edges does not clear the held code.
- R7: The 9th consecutive high sample of `sel_in` clears the held code to 0. This also gives the power-up clear.
- R8: Once cleared, error strobes are discarded for as long as `sel_in` stays high.
- R9: Error strobes that arrive during a select-high run that is still short are gathered as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| sel_in | input | 1 | Select input: low shows the error code, a long high clears it |
| err_evt | input | 7 | Error strobes, one bit per condition, bit 6 most severe |
| err_code | output | 3 | Held error code, or 0 while `sel_in` is high |

## Verification
The function is driven in several ways:

- Single strobes on the lowest, the highest and a middle bit check the code mapping.
- A strobe pattern with several bits set separates a true highest-bit encoder from an OR or lowest-bit encoder.
- A lower strobe after a higher one, followed by a higher one, separates a "strictly greater" update from "last error wins".
- Select-high runs of exactly 8 and exactly 9 samples find the clear boundary, which an off-by-one counter would miss.
- A strobe inside a short run shows that gathering goes on while counting.
- A strobe inside a run past the limit shows that errors are discarded after the clear.

A behavioural model is compared with `err_code` on every cycle as well.

// File: rtl/sticky_err_pkg.sv
package sticky_err_pkg;
    typedef enum logic [1:0] {
        ST_WATCH = 2'd0,
        ST_COUNT = 2'd1,
        ST_CLEAR = 2'd2
    } clr_state_t;
endpackage

// File: rtl/err_prio_enc.sv
module err_prio_enc #(
    parameter int NUM_ERR = 7,
    parameter int CODE_W  = $clog2(NUM_ERR + 1)
) (
    input  logic [NUM_ERR-1:0] evt,
    output logic [CODE_W-1:0]  code
);
    // Ascending scan: the highest set bit is written last and wins.
    always_comb begin
        code = '0;
        for (int i = 0; i < NUM_ERR; i++) begin
            if (evt[i]) code = CODE_W'(i + 1);
        end
    end
endmodule

// File: rtl/clr_fsm.sv
module clr_fsm
    import sticky_err_pkg::*;
#(
    parameter int CLR_LEN = 8,
    parameter int CNT_W   = $clog2(CLR_LEN + 1)
) (
    input  logic clk,
    input  logic sel,
    output logic wipe
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CLR_LEN);

    clr_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!sel) begin
            state_d = ST_WATCH;              // go_watch
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_WATCH, ST_COUNT: begin
                    if (cnt_q == LIMIT) begin
                        state_d = ST_CLEAR;  // go_clear
                    end else begin
                        state_d = ST_COUNT;  // go_count / stay_count
                        cnt_d   = cnt_q + 1'b1;
                    end
                end
                ST_CLEAR: state_d = ST_CLEAR; // hold_clear
                default:  state_d = ST_WATCH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // outputs
    always_comb begin
        wipe = 1'b0;
        if (sel) begin
            unique case (state_q)
                ST_CLEAR:           wipe = 1'b1;
                ST_WATCH, ST_COUNT: wipe = (cnt_q == LIMIT);
                default:            wipe = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/code_hold.sv
module code_hold #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              wipe,
    input  logic [CODE_W-1:0] new_code,
    output logic [CODE_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (wipe)                held <= '0;
        else if (new_code > held) held <= new_code;
    end
endmodule

// File: rtl/sticky_err_reporter.sv
module sticky_err_reporter #(
    parameter int NUM_ERR = 7,
    parameter int CLR_LEN = 8,
    localparam int CODE_W = $clog2(NUM_ERR + 1)
) (
    input  logic               mclk,
    input  logic               sel_in,
    input  logic [NUM_ERR-1:0] err_evt,
    output logic [CODE_W-1:0]  err_code
);
    logic [CODE_W-1:0] enc_code;
    logic [CODE_W-1:0] held_q;
    logic              wipe;

    err_prio_enc #(.NUM_ERR(NUM_ERR), .CODE_W(CODE_W)) u_enc (
        .evt  (err_evt),
        .code (enc_code)
    );

    clr_fsm #(.CLR_LEN(CLR_LEN)) u_fsm (
        .clk  (mclk),
        .sel  (sel_in),
        .wipe (wipe)
    );

    code_hold #(.CODE_W(CODE_W)) u_hold (
        .clk      (mclk),
        .wipe     (wipe),
        .new_code (enc_code),
        .held     (held_q)
    );

    assign err_code = sel_in ? '0 : held_q;
endmodule

// File: rtl/sticky_err_chk.sv
module sticky_err_chk #(
    parameter int NUM_ERR = 7,
    parameter int CLR_LEN = 8,
    parameter int CODE_W  = 3
) (
    input logic               clk,
    input logic               sel,
    input logic [NUM_ERR-1:0] evt,
    input logic [CODE_W-1:0]  code,
    input logic [CODE_W-1:0]  held,
    input logic               wipe
);
    logic armed = 1'b0;
    int   hc    = 0;

    always_ff @(posedge clk) begin
        if (wipe) armed <= 1'b1;
        if (sel)  hc <= (hc > CLR_LEN) ? hc : hc + 1;
        else      hc <= 0;
    end

    p_blank_when_sel_r5: assert property (@(posedge clk) disable iff (!armed)
        sel |-> code == '0);
    p_no_drop_r4: assert property (@(posedge clk) disable iff (!armed)
        !wipe |=> held >= $past(held));
    p_wipe_zero_r7: assert property (@(posedge clk) disable iff (!armed)
        wipe |=> held == '0);
    p_wipe_window_r6: assert property (@(posedge clk) disable iff (!armed)
        wipe == (sel && hc >= CLR_LEN));
    p_latch_r3: assert property (@(posedge clk) disable iff (!armed)
        (evt != '0 && !wipe) |=> held != '0);
    p_low_no_wipe_r8: assert property (@(posedge clk) disable iff (!armed)
        !sel |=> !wipe);
endmodule

bind sticky_err_reporter sticky_err_chk #(
    .NUM_ERR(NUM_ERR), .CLR_LEN(CLR_LEN), .CODE_W(CODE_W)
) u_chk (
    .clk  (mclk),
    .sel  (sel_in),
    .evt  (err_evt),
    .code (err_code),
    .held (held_q),
    .wipe (wipe)
);

// File: tb/test_sticky_err_reporter.sv
`timescale 1ns/1ps
module test_sticky_err_reporter;
    logic       mclk = 1'b0;
    logic       sel_in = 1'b0;
    logic [6:0] err_evt = '0;
    logic [2:0] err_code;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;
    string phase = "init";

    int m_held = 0;
    int m_run  = 0;

    always #4 mclk = ~mclk;

    sticky_err_reporter i_sticky_err_reporter (
        .mclk(mclk), .sel_in(sel_in), .err_evt(err_evt), .err_code(err_code)
    );

    function automatic int sev(logic [6:0] e);
        for (int b = 6; b >= 0; b--) if (e[b]) return b + 1;
        return 0;
    endfunction

    // behavioural model
    always @(posedge mclk) begin
        if (sel_in) begin
            m_run = m_run + 1;
            if (m_run > 8) m_held = 0;
            else if (sev(err_evt) > m_held) m_held = sev(err_evt);
        end else begin
            m_run = 0;
            if (sev(err_evt) > m_held) m_held = sev(err_evt);
        end
    end

    always @(posedge mclk) begin
        #2;
        if (cmp_en) begin
            checks++;
            if (int'(err_code) != (sel_in ? 0 : m_held)) begin
                errors++;
                $display("FAIL model %s: got %0d exp %0d", phase, err_code,
                         sel_in ? 0 : m_held);
            end
        end
    end

    task automatic drive(input logic s, input logic [6:0] e);
        sel_in  = s;
        err_evt = e;
        @(negedge mclk);
    endtask

    task automatic expect_code(input int exp, input string tag);
        checks++;
        if (int'(err_code) != exp) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, err_code, exp);
        end
    endtask

    task automatic hold_sel(input int n);
        for (int k = 0; k < n; k++) drive(1'b1, '0);
        drive(1'b0, '0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hang exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge mclk);
        drive(1'b0, '0); drive(1'b0, '0);
        hold_sel(10);                          // power-up clear, R7
        m_held = 0;
        cmp_en = 1'b1;
        expect_code(0, "R7 reset state");

        phase = "R1";
        drive(1'b0, 7'b0000001); drive(1'b0, '0);
        expect_code(1, "R1 validity");
        hold_sel(10);
        drive(1'b0, 7'b1000000); drive(1'b0, '0);
        expect_code(7, "R1 loss of lock");
        hold_sel(10);
        drive(1'b0, 7'b0001000); drive(1'b0, '0);
        expect_code(4, "R1 CRC");
        hold_sel(10);

        phase = "R2";
        drive(1'b0, 7'b0010110);
        expect_code(5, "R2 simultaneous");

        phase = "R3";
        for (int k = 0; k < 5; k++) drive(1'b0, '0);
        expect_code(5, "R3 sticky");

        phase = "R4";
        drive(1'b0, 7'b0000010); drive(1'b0, '0);
        expect_code(5, "R4 lower ignored");
        drive(1'b0, 7'b0010000); drive(1'b0, '0);
        expect_code(5, "R4 equal ignored");
        drive(1'b0, 7'b0100000); drive(1'b0, '0);
        expect_code(6, "R4 higher replaces");

        phase = "R5";
        drive(1'b1, '0);
        expect_code(0, "R5 blank while high");
        drive(1'b1, '0);
        expect_code(0, "R5 blank while high");
        drive(1'b0, '0);
        expect_code(6, "R5 shown when low");

        phase = "R6";
        hold_sel(8);
        expect_code(6, "R6 eight highs keep code");

        phase = "R9";
        drive(1'b1, '0); drive(1'b1, '0);
        drive(1'b1, 7'b1000000); drive(1'b1, '0);
        drive(1'b0, '0);
        expect_code(7, "R9 gathered during short run");

        phase = "R7";
        hold_sel(9);
        expect_code(0, "R7 ninth high clears");

        phase = "R8";
        drive(1'b0, 7'b0000100); drive(1'b0, '0);
        expect_code(3, "R8 setup");
        for (int k = 0; k < 10; k++) drive(1'b1, '0);
        drive(1'b1, 7'b1000000); drive(1'b1, 7'b0000001);
        drive(1'b0, '0);
        expect_code(0, "R8 discarded after clear");

        drive(1'b0, '0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule